// File: doc/BRIEF.md
# Prebias Synchronous Rectifier Ramp

This block governs the low-side switch of a synchronous buck converter while it starts into an output that already holds a voltage. It holds off all switching until a comparator reports that the soft-start level has climbed above the feedback level. From then on it issues a low-side on-time per switching cycle that begins narrow and grows by a fixed step on each cycle strobe, until it reaches the complementary duty interval (the 1-D time) that the loop asks for. Because the rectifier is widened slowly, the converter does not pull current back out of the precharged load.

The loop supplies the target on-time in clock ticks; the block never issues more than that target. It follows a shrinking target at once. Once it has reached the target, it follows the target directly. A restart input returns the block to its waiting state, so that the next start again begins from the narrow value.

Top module: `prebiasRampTop`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, pwmEnable is 0, lsOnTime is 0 and rampDone is 0.
- R2: While waiting, pwmEnable stays 0 and lsOnTime stays 0 for as long as ssAboveFb is sampled low, regardless of cycleStrobe and targetOnTime.
- R3: If ssAboveFb is sampled high while waiting and restart is low, then in the next cycle pwmEnable is 1 and lsOnTime equals the smaller of INIT_TICKS and the target sampled at that edge. rampDone is then 1 exactly when INIT_TICKS is at least that target.
- R4: While running and not done, a sampled cycleStrobe raises lsOnTime by STEP_TICKS in the next cycle, capped at the sampled target. Without a strobe, lsOnTime holds its value (capped at the target).
- R5: While running, lsOnTime never exceeds the target sampled one cycle earlier. If the target falls below the current value, lsOnTime equals the new target in the next cycle.
- R6: rampDone rises in the same cycle in which lsOnTime first equals the target. It stays set until restart, and while it is set lsOnTime equals the target sampled one cycle earlier.
- R7: A sampled restart clears pwmEnable, lsOnTime and rampDone in the next cycle. It takes priority over ssAboveFb. A new start then needs ssAboveFb high again.
- R8: Once running, ssAboveFb has no effect: pwmEnable stays 1 and lsOnTime follows R4 to R6 even when the comparator drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Return to waiting state, drop enable and done |
| ssAboveFb | input | 1 | Comparator flag: soft-start level above feedback |
| cycleStrobe | input | 1 | One pulse per switching cycle |
| targetOnTime | input | W | Steady-state low-side on-time (1-D) in ticks |
| pwmEnable | output | 1 | Switching permitted |
| lsOnTime | output | W | Low-side on-time for the current cycle in ticks |
| rampDone | output | 1 | On-time has reached the target |

## Verification
The assertions take for granted that ssAboveFb, cycleStrobe, restart and targetOnTime are synchronous to clk and stable around the sampling edge. They also assume that targetOnTime is a plain unsigned tick count, for which the only constraint is the port width. No rule is assumed about how often the strobe occurs or how the target moves. The stimulus drives every input on the falling edge. It mixes long stable targets with occasional jumps up and down, rare restarts and a comparator that drops while the block is running. With narrow targets and wide targets, the start value, the saturation point and the done edge all occur many times.

// File: rtl/prebiasPkg.sv
package prebiasPkg;
  typedef enum logic {ST_WAIT = 1'b0, ST_RUN = 1'b1} rampState_t;

  typedef struct packed {
    logic clear;  // drop to zero, clear done
    logic load;   // start from the narrow initial value
    logic run;    // ramp / track active this cycle
    logic step;   // widen by one step this cycle
  } rampCmd_t;
endpackage

// File: rtl/prebiasCtrl.sv
module prebiasCtrl
  import prebiasPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     restart,
  input  logic     ssAboveFb,
  input  logic     cycleStrobe,
  output rampCmd_t cmd,
  output logic     pwmEnable
);
  rampState_t state;

  always_comb begin
    cmd = '0;
    if (restart) begin
      cmd.clear = 1'b1;
    end else if (state == ST_WAIT) begin
      cmd.load = ssAboveFb;
    end else begin
      cmd.run  = 1'b1;
      cmd.step = cycleStrobe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_WAIT;
    end else if (restart) begin
      state <= ST_WAIT;
    end else if (state == ST_WAIT && ssAboveFb) begin
      state <= ST_RUN;
    end
  end

  assign pwmEnable = (state == ST_RUN);
endmodule

// File: rtl/prebiasDatapath.sv
module prebiasDatapath
  import prebiasPkg::*;
#(
  parameter int W          = 10,
  parameter int INIT_TICKS = 4,
  parameter int STEP_TICKS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  rampCmd_t     cmd,
  input  logic [W-1:0] targetOnTime,
  output logic [W-1:0] lsOnTime,
  output logic         rampDone
);
  localparam logic [W:0] INIT_WIDE = (W+1)'(INIT_TICKS);
  localparam logic [W:0] STEP_WIDE = (W+1)'(STEP_TICKS);

  logic [W:0]   tgtWide;
  logic [W:0]   stepped;
  logic [W-1:0] startVal;
  logic [W-1:0] nextVal;

  assign tgtWide  = {1'b0, targetOnTime};
  assign stepped  = {1'b0, lsOnTime} + STEP_WIDE;
  assign startVal = (INIT_WIDE >= tgtWide) ? targetOnTime : INIT_WIDE[W-1:0];

  always_comb begin
    if (rampDone) begin
      nextVal = targetOnTime;
    end else if (cmd.step) begin
      nextVal = (stepped >= tgtWide) ? targetOnTime : stepped[W-1:0];
    end else begin
      nextVal = (lsOnTime > targetOnTime) ? targetOnTime : lsOnTime;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) begin
      lsOnTime <= '0;
      rampDone <= 1'b0;
    end else if (cmd.load) begin
      lsOnTime <= startVal;
      rampDone <= (INIT_WIDE >= tgtWide);
    end else if (cmd.run) begin
      lsOnTime <= nextVal;
      rampDone <= rampDone | (nextVal == targetOnTime);
    end
  end
endmodule

// File: rtl/prebiasRampTop.sv
module prebiasRampTop
  import prebiasPkg::*;
#(
  parameter int W          = 10,
  parameter int INIT_TICKS = 4,
  parameter int STEP_TICKS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         restart,
  input  logic         ssAboveFb,
  input  logic         cycleStrobe,
  input  logic [W-1:0] targetOnTime,
  output logic         pwmEnable,
  output logic [W-1:0] lsOnTime,
  output logic         rampDone
);
  rampCmd_t cmd;

  prebiasCtrl uCtrl (
    .clk(clk), .rstN(rstN), .restart(restart), .ssAboveFb(ssAboveFb),
    .cycleStrobe(cycleStrobe), .cmd(cmd), .pwmEnable(pwmEnable)
  );

  prebiasDatapath #(.W(W), .INIT_TICKS(INIT_TICKS), .STEP_TICKS(STEP_TICKS)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .targetOnTime(targetOnTime),
    .lsOnTime(lsOnTime), .rampDone(rampDone)
  );
endmodule

// File: rtl/prebiasRampChecker.sv
module prebiasRampChecker #(
  parameter int W          = 10,
  parameter int INIT_TICKS = 4,
  parameter int STEP_TICKS = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         restart,
  input logic         ssAboveFb,
  input logic         cycleStrobe,
  input logic [W-1:0] targetOnTime,
  input logic         pwmEnable,
  input logic [W-1:0] lsOnTime,
  input logic         rampDone
);
  localparam logic [W:0] INIT_WIDE = (W+1)'(INIT_TICKS);
  localparam logic [W:0] STEP_WIDE = (W+1)'(STEP_TICKS);

  initial begin
    assert_param_sane_R4: assert (INIT_TICKS > 0 && STEP_TICKS > 0);
  end

  // R2: idle means zero on-time and no done
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEnable |-> (lsOnTime == '0 && !rampDone));

  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmEnable && !ssAboveFb) |=> !pwmEnable);

  // R3: narrow start value
  assert_start_narrow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmEnable && ssAboveFb && !restart) |=>
      (pwmEnable && {1'b0, lsOnTime} <= INIT_WIDE));

  // R4: growth bounded by one step
  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && !restart && !rampDone) |=>
      ({1'b0, lsOnTime} <= {1'b0, $past(lsOnTime)} + STEP_WIDE));

  assert_no_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && !restart && !rampDone && !cycleStrobe) |=>
      (lsOnTime <= $past(lsOnTime)));

  // R5: never above target
  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rstN)
    pwmEnable |=> (lsOnTime <= $past(targetOnTime)));

  // R6: done sticky and locked to target
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rampDone && !restart) |=> rampDone);

  assert_done_tracks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rampDone && !restart) |=> (lsOnTime == $past(targetOnTime)));

  // R7: restart clears
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!pwmEnable && !rampDone && lsOnTime == '0));

  // R8: comparator ignored while running
  assert_run_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEnable && !restart) |=> pwmEnable);
endmodule

bind prebiasRampTop prebiasRampChecker #(.W(W), .INIT_TICKS(INIT_TICKS), .STEP_TICKS(STEP_TICKS)) uChk (
  .clk(clk), .rstN(rstN), .restart(restart), .ssAboveFb(ssAboveFb),
  .cycleStrobe(cycleStrobe), .targetOnTime(targetOnTime),
  .pwmEnable(pwmEnable), .lsOnTime(lsOnTime), .rampDone(rampDone)
);

// File: tb/sim_prebiasRampTop.sv
`timescale 1ns/1ps
module sim_prebiasRampTop;
  localparam int W = 10;
  localparam int INIT_TICKS = 4;
  localparam int STEP_TICKS = 2;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic restart = 1'b0;
  logic ssAboveFb = 1'b0;
  logic cycleStrobe = 1'b0;
  logic [W-1:0] targetOnTime = '0;
  logic pwmEnable;
  logic [W-1:0] lsOnTime;
  logic rampDone;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // bench reference state
  bit mEn = 1'b0;
  int mOn = 0;
  bit mDone = 1'b0;
  string mTag = "R1";

  always #5 clk = ~clk;

  prebiasRampTop #(.W(W), .INIT_TICKS(INIT_TICKS), .STEP_TICKS(STEP_TICKS)) u0 (
    .clk(clk), .rstN(rstN), .restart(restart), .ssAboveFb(ssAboveFb),
    .cycleStrobe(cycleStrobe), .targetOnTime(targetOnTime),
    .pwmEnable(pwmEnable), .lsOnTime(lsOnTime), .rampDone(rampDone)
  );

  function automatic int minOf(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic checkOut(string tag);
    testsRun++;
    if (pwmEnable !== mEn || int'(lsOnTime) != mOn || rampDone !== mDone) begin
      testsFailed++;
      $display("FAIL %s: en/on/done actual %0b/%0d/%0b expected %0b/%0d/%0b",
               tag, pwmEnable, lsOnTime, rampDone, mEn, mOn, mDone);
    end
  endtask

  // one clock: drive at falling edge, advance model at rising edge, compare
  task automatic cyc(bit r, bit ss, bit st, int tg);
    restart = r; ssAboveFb = ss; cycleStrobe = st; targetOnTime = W'(tg);
    @(posedge clk);
    if (r) begin
      mEn = 0; mOn = 0; mDone = 0; mTag = "R7";
    end else if (!mEn) begin
      if (ss) begin
        mEn = 1; mOn = minOf(INIT_TICKS, tg); mDone = (INIT_TICKS >= tg); mTag = "R3";
      end else mTag = "R2";
    end else if (mDone) begin
      mOn = tg; mTag = "R6";
    end else begin
      int nv;
      nv = st ? minOf(mOn + STEP_TICKS, tg) : minOf(mOn, tg);
      mTag = (!ss) ? "R8" : (st ? "R4" : "R5");
      mOn = nv;
      mDone = (nv == tg);
    end
    @(negedge clk);
    checkOut(mTag);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    checkOut("R1");
    rstN = 1'b1;
    checkOut("R1");

    // R2: comparator low, strobes and targets ignored
    for (int i = 0; i < 12; i++) cyc(0, 0, i[0], 40 + i);
    // R3: start narrow
    cyc(0, 1, 0, 40);
    // R4 then R6: ramp to saturation with odd distance
    for (int i = 0; i < 25; i++) cyc(0, 1, 1, 41);
    // R6: after done, follows target up and down
    cyc(0, 1, 0, 60);
    cyc(0, 1, 1, 10);
    // R7: restart, then start with target below INIT_TICKS (immediate done)
    cyc(1, 1, 1, 10);
    cyc(0, 1, 0, 3);
    cyc(1, 0, 0, 3);
    // R5: shrink mid-ramp
    cyc(0, 1, 0, 100);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 100);
    cyc(0, 1, 0, 7);
    // R8: comparator drops while running
    cyc(1, 0, 0, 100);
    cyc(0, 1, 0, 100);
    for (int i = 0; i < 10; i++) cyc(0, 0, i[0], 100);
    // restart together with comparator high: restart wins (R7)
    cyc(1, 1, 1, 100);
    // max target boundary
    cyc(0, 1, 0, MAXV);
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, MAXV);

    // constrained random
    begin
      int tg = 50;
      for (int i = 0; i < 6000; i++) begin
        bit r, ss, st;
        if ($urandom_range(0, 39) == 0) begin
          case ($urandom_range(0, 3))
            0: tg = $urandom_range(0, 8);
            1: tg = $urandom_range(0, MAXV);
            default: tg = $urandom_range(10, 120);
          endcase
        end
        r  = ($urandom_range(0, 299) == 0);
        ss = ($urandom_range(0, 3) != 0);
        st = ($urandom_range(0, 2) == 0);
        cyc(r, ss, st, tg);
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule